// File: doc/BRIEF.md
# Serial DAC Command Frame Transmitter

This block is the host-side master for a three-wire serial link into one or more cascaded digital-to-analog converter devices. The wires are a data line, a shift clock and a load strobe. Each request carries one command per device in the chain. A command has a 4-bit channel address, two option bits and a 6-bit output level. The block packs every command into a 12-bit frame and shifts all frames out, most significant bit first, on a slow shift clock. It then raises one load strobe that latches every device in the chain at once.

Every serial interval is counted in system clock cycles: clock high, clock low, data setup, data hold, the lead before the strobe, the strobe width and the lag after it. Each count is derived from the system clock frequency and a time in nanoseconds, and is rounded up. A ready/valid handshake takes a new request only when the previous transfer has fully finished, lag time included.

Top module: `dac_frame_tx`

## Requirements
- R1: Each 12-bit frame carries the address in bits 11..8, the option bits in 7..6 and the level in 5..0, and bit 11 is sent first.
- R2: With CHAIN devices, the command in slot CHAIN-1 (the device farthest from the host) is sent first and slot 0 is sent last. Exactly 12×CHAIN rising shift clock edges precede a single load pulse.
- R3: The shift clock stays high for at least the high-time count and low for at least the low-time count between consecutive rising edges of one transfer.
- R4: The data line is stable for at least the setup count before each rising shift clock edge. It does not change for at least the hold count after that edge.
- R5: At least the lead count of cycles separates the last falling shift clock edge from the rise of the load strobe, and the shift clock stays low while the strobe is high.
- R6: The load strobe is high for at least the strobe-width count.
- R7: No rising shift clock edge occurs, and ready stays low, until at least the lag count of cycles after the load strobe falls.
- R8: A request is taken on a cycle where req_valid and req_ready are both high. Ready drops the cycle after acceptance, and request inputs presented while ready is low have no effect on the frames sent.
- R9: After reset the shift clock, load strobe and data line are low and ready is high.
- R10: Each count equals ceil(time_ns × CLK_KHZ / 10^6). The shift clock high time and the strobe width come out exactly at their counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 4×CHAIN | Channel address per device, slot k at bits 4k+3..4k |
| req_opt | input | 2×CHAIN | Option bits per device, slot k at bits 2k+1..2k |
| req_level | input | 6×CHAIN | Output level per device, slot k at bits 6k+5..6k |
| ser_data | output | 1 | Serial data to the first device |
| ser_clk | output | 1 | Shift clock, idles low |
| ser_load | output | 1 | Load strobe, idles low |

## Verification
A shift register holding stale or wrong bits shows up at the first load strobe as a word that differs from the packed commands. A bit counter that is off by one shows up as a wrong number of clock edges before the strobe. A timer loaded with the wrong count shows up at the very next shift clock or strobe edge, as a high time, low time, setup, hold, lead or lag interval shorter than its count. A handshake that takes data while busy corrupts the next word compared, or leaves an expected word unconsumed when the run ends.

// File: rtl/dac_tx_pkg.sv
package dac_tx_pkg;

  localparam int FRAME_W = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_REST,
    ST_LEAD,
    ST_LOAD,
    ST_LAG
  } tx_state_e;

  function automatic int ceil_cycles(input longint t_ns, input longint f_khz);
    return int'((t_ns * f_khz + 64'd999999) / 64'd1000000);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dac_frame_pack.sv
module dac_frame_pack
  import dac_tx_pkg::*;
#(
  parameter int CHAIN = 1,
  localparam int NB = CHAIN * FRAME_W
) (
  input  logic [CHAIN*4-1:0] addr,
  input  logic [CHAIN*2-1:0] opt,
  input  logic [CHAIN*6-1:0] level,
  output logic [NB-1:0]      word
);

  // Slot k occupies word[12k+11:12k]; the highest slot leaves first.
  for (genvar k = 0; k < CHAIN; k++) begin : g_slot
    assign word[k*FRAME_W +: FRAME_W] = {addr[k*4 +: 4], opt[k*2 +: 2], level[k*6 +: 6]};
  end

endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          done
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = len - CW'(1);
    else      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R10: once expired, the timer holds at zero until reloaded
  a_r10_timer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && done) |=> done);

  // R10: a length of one expires on the cycle after loading
  a_r10_len_one: assert property (@(posedge clk) disable iff (!rst_n)
    (load && len == CW'(1)) |=> done);

endmodule

// File: rtl/dac_tx_seq.sv
module dac_tx_seq
  import dac_tx_pkg::*;
#(
  parameter int CHAIN   = 1,
  parameter int CW      = 8,
  parameter int SETUP_C = 1,
  parameter int HIGH_C  = 1,
  parameter int REST_C  = 1,
  parameter int LEAD_C  = 1,
  parameter int LDW_C   = 1,
  parameter int LAG_C   = 1,
  localparam int NB = CHAIN * FRAME_W,
  localparam int BW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [NB-1:0] word,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_len,
  input  logic          tmr_done,
  output logic          ser_data,
  output logic          ser_clk,
  output logic          ser_load
);

  tx_state_e     state_q, state_d;
  logic [NB-1:0] sreg_q, sreg_d;
  logic [BW-1:0] left_q, left_d;
  logic          sclk_q, sclk_d;
  logic          ld_q, ld_d;
  logic          upd_en;

  always_comb begin
    state_d  = state_q;
    sreg_d   = sreg_q;
    left_d   = left_q;
    sclk_d   = sclk_q;
    ld_d     = ld_q;
    tmr_load = 1'b0;
    tmr_len  = CW'(1);
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        sreg_d = word;
        left_d = BW'(NB - 1);
        state_d = ST_SETUP;
        tmr_load = 1'b1; tmr_len = CW'(SETUP_C);
      end
      ST_SETUP: if (tmr_done) begin
        sclk_d = 1'b1;
        state_d = ST_HIGH;
        tmr_load = 1'b1; tmr_len = CW'(HIGH_C);
      end
      ST_HIGH: if (tmr_done) begin
        sclk_d = 1'b0;
        tmr_load = 1'b1;
        if (left_q == '0) begin
          state_d = ST_LEAD; tmr_len = CW'(LEAD_C);
        end else begin
          state_d = ST_REST; tmr_len = CW'(REST_C);
        end
      end
      ST_REST: if (tmr_done) begin
        sreg_d = {sreg_q[NB-2:0], 1'b0};
        left_d = left_q - BW'(1);
        state_d = ST_SETUP;
        tmr_load = 1'b1; tmr_len = CW'(SETUP_C);
      end
      ST_LEAD: if (tmr_done) begin
        ld_d = 1'b1;
        state_d = ST_LOAD;
        tmr_load = 1'b1; tmr_len = CW'(LDW_C);
      end
      ST_LOAD: if (tmr_done) begin
        ld_d = 1'b0;
        state_d = ST_LAG;
        tmr_load = 1'b1; tmr_len = CW'(LAG_C);
      end
      ST_LAG: if (tmr_done) begin
        sreg_d = '0;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign upd_en = (state_q == ST_IDLE) ? req_valid : tmr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sreg_q  <= '0;
      left_q  <= '0;
      sclk_q  <= 1'b0;
      ld_q    <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      sreg_q  <= sreg_d;
      left_q  <= left_d;
      sclk_q  <= sclk_d;
      ld_q    <= ld_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign ser_data  = sreg_q[NB-1];
  assign ser_clk   = sclk_q;
  assign ser_load  = ld_q;

  // Assertion-only run length of the shift clock high phase
  logic [CW-1:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_run_q <= '0;
    else if (sclk_q) hi_run_q <= hi_run_q + CW'(1);
    else             hi_run_q <= '0;
  end

  a_r3_high_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) |-> (hi_run_q >= CW'(HIGH_C)));

  a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(ser_data));

  a_r5_no_clk_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_q |-> !sclk_q);

  a_r2_load_after_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_q) |-> (left_q == '0));

  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
  import dac_tx_pkg::*;
#(
  parameter int CHAIN      = 1,
  parameter int CLK_KHZ    = 125000,
  parameter int T_HIGH_NS  = 4000,
  parameter int T_LOW_NS   = 10000,
  parameter int T_SETUP_NS = 2000,
  parameter int T_HOLD_NS  = 10000,
  parameter int T_LEAD_NS  = 10000,
  parameter int T_LDW_NS   = 4000,
  parameter int T_LAG_NS   = 10000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [CHAIN*4-1:0]   req_addr,
  input  logic [CHAIN*2-1:0]   req_opt,
  input  logic [CHAIN*6-1:0]   req_level,
  output logic                 ser_data,
  output logic                 ser_clk,
  output logic                 ser_load
);

  localparam int NB      = CHAIN * FRAME_W;
  localparam int HIGH_C  = max3(ceil_cycles(T_HIGH_NS, CLK_KHZ), 1, 1);
  localparam int LOW_C   = ceil_cycles(T_LOW_NS, CLK_KHZ);
  localparam int SETUP_C = max3(ceil_cycles(T_SETUP_NS, CLK_KHZ), 1, 1);
  localparam int HOLD_C  = ceil_cycles(T_HOLD_NS, CLK_KHZ);
  localparam int REST_C  = max3(HOLD_C - HIGH_C, LOW_C - SETUP_C, 1);
  localparam int LEAD_C  = max3(ceil_cycles(T_LEAD_NS, CLK_KHZ), HOLD_C - HIGH_C, 1);
  localparam int LDW_C   = max3(ceil_cycles(T_LDW_NS, CLK_KHZ), 1, 1);
  localparam int LAG_C   = max3(ceil_cycles(T_LAG_NS, CLK_KHZ), 1, 1);
  localparam int MAX_C   = max3(max3(HIGH_C, SETUP_C, REST_C), max3(LEAD_C, LDW_C, LAG_C), 1);
  localparam int CW      = $clog2(MAX_C + 1);

  // Asynchronous assertion, synchronous release
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic [NB-1:0] word;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_len;

  dac_frame_pack #(.CHAIN(CHAIN)) u_pack (
    .addr (req_addr),
    .opt  (req_opt),
    .level(req_level),
    .word (word)
  );

  dac_phase_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst_n(rst_q),
    .load (tmr_load),
    .len  (tmr_len),
    .done (tmr_done)
  );

  dac_tx_seq #(
    .CHAIN  (CHAIN),
    .CW     (CW),
    .SETUP_C(SETUP_C),
    .HIGH_C (HIGH_C),
    .REST_C (REST_C),
    .LEAD_C (LEAD_C),
    .LDW_C  (LDW_C),
    .LAG_C  (LAG_C)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_q),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .word     (word),
    .tmr_load (tmr_load),
    .tmr_len  (tmr_len),
    .tmr_done (tmr_done),
    .ser_data (ser_data),
    .ser_clk  (ser_clk),
    .ser_load (ser_load)
  );

endmodule

// File: tb/tb_dac_frame_tx.sv
`timescale 1ns/1ps
module tb_dac_frame_tx;

  localparam int CHAIN = 2;
  localparam int KHZ   = 1100;
  localparam int NB    = CHAIN * 12;

  function automatic int up(input int ns);
    return (ns * KHZ + 999999) / 1000000;
  endfunction

  localparam int E_HIGH  = up(4000);
  localparam int E_LOW   = up(10000);
  localparam int E_SETUP = up(2000);
  localparam int E_HOLD  = up(10000);
  localparam int E_LEAD  = up(10000);
  localparam int E_LDW   = up(4000);
  localparam int E_LAG   = up(10000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [CHAIN*4-1:0] req_addr = '0;
  logic [CHAIN*2-1:0] req_opt = '0;
  logic [CHAIN*6-1:0] req_level = '0;
  logic ser_data, ser_clk, ser_load;

  always #4 clk = ~clk;

  dac_frame_tx #(.CHAIN(CHAIN), .CLK_KHZ(KHZ)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_opt(req_opt), .req_level(req_level),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_load(ser_load)
  );

  int checks = 0;
  int errors = 0;
  logic [NB-1:0] expq[$];
  int sent = 0;
  int seen = 0;
  bit mon_on = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: slot 1 is the far device, slot 0 the near one
  task automatic send(input logic [3:0] a1, input logic [1:0] o1, input logic [5:0] l1,
                      input logic [3:0] a0, input logic [1:0] o0, input logic [5:0] l0);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr  = {a1, a0};
    req_opt   = {o1, o0};
    req_level = {l1, l0};
    req_valid = 1'b1;
    expq.push_back({a1, o1, l1, a0, o0, l0});
    sent++;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R8 ready low after accept", req_ready, 0);
    // R8: junk requests while busy must be ignored
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = ~req_addr;
      req_level = req_level + 6'd7;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    int cyc = 0;
    int t_rise = -100000, t_fall = -100000, t_dchg = -100000;
    int t_ldr = -100000, t_ldf = -100000;
    int nbits = 0;
    logic [NB-1:0] got = '0;
    logic p_clk = 0, p_ld = 0, p_dat = 0, p_rdy = 1;
    wait (mon_on);
    forever begin
      @(negedge clk);
      cyc++;
      if (ser_data !== p_dat) begin
        if (t_rise >= 0)
          chk(cyc - t_rise >= E_HOLD, "R4 hold", cyc - t_rise, E_HOLD);
        t_dchg = cyc;
      end
      if (ser_clk && !p_clk) begin
        chk(cyc - t_dchg >= E_SETUP, "R4 setup", cyc - t_dchg, E_SETUP);
        if (t_fall > t_ldf)
          chk(cyc - t_fall >= E_LOW, "R3 low time", cyc - t_fall, E_LOW);
        if (t_ldf >= 0)
          chk(cyc - t_ldf >= E_LAG, "R7 lag before clock", cyc - t_ldf, E_LAG);
        got = {got[NB-2:0], ser_data};
        nbits++;
        t_rise = cyc;
      end
      if (!ser_clk && p_clk) begin
        chk(cyc - t_rise == E_HIGH, "R10 high count", cyc - t_rise, E_HIGH);
        chk(cyc - t_rise >= E_HIGH, "R3 high time", cyc - t_rise, E_HIGH);
        t_fall = cyc;
      end
      if (ser_load && !p_ld) begin
        chk(cyc - t_fall >= E_LEAD, "R5 lead", cyc - t_fall, E_LEAD);
        chk(ser_clk == 1'b0, "R5 clock low at load", ser_clk, 0);
        chk(nbits == NB, "R2 bit count", nbits, NB);
        if (expq.size() == 0) begin
          chk(0, "R8 unexpected frame", got, 0);
        end else begin
          logic [NB-1:0] e;
          e = expq.pop_front();
          chk(got == e, "R1 R2 frame word", got, e);
        end
        seen++;
        nbits = 0;
        t_ldr = cyc;
      end
      if (ser_load && ser_clk)
        chk(0, "R5 clock during load", 1, 0);
      if (!ser_load && p_ld) begin
        chk(cyc - t_ldr == E_LDW, "R10 load width count", cyc - t_ldr, E_LDW);
        chk(cyc - t_ldr >= E_LDW, "R6 load width", cyc - t_ldr, E_LDW);
        t_ldf = cyc;
      end
      if (req_ready && !p_rdy)
        chk(cyc - t_ldf >= E_LAG, "R7 ready after lag", cyc - t_ldf, E_LAG);
      p_clk = ser_clk; p_ld = ser_load; p_dat = ser_data; p_rdy = req_ready;
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(ser_clk == 1'b0, "R9 reset clock", ser_clk, 0);
    chk(ser_load == 1'b0, "R9 reset load", ser_load, 0);
    chk(ser_data == 1'b0, "R9 reset data", ser_data, 0);
    chk(req_ready == 1'b1, "R9 reset ready", req_ready, 1);
    mon_on = 1;
    send(4'h1, 2'b01, 6'h2A, 4'h8, 2'b10, 6'h15);
    send(4'h0, 2'b00, 6'h00, 4'h0, 2'b00, 6'h00);
    send(4'hF, 2'b11, 6'h3F, 4'hF, 2'b11, 6'h3F);
    send(4'hA, 2'b10, 6'h01, 4'h5, 2'b01, 6'h20);
    send(4'h3, 2'b00, 6'h3E, 4'hC, 2'b11, 6'h00);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(seen == sent, "R8 frames delivered", seen, sent);
    chk(expq.size() == 0, "R2 queue drained", expq.size(), 0);
    chk(ser_clk == 1'b0 && ser_load == 1'b0, "R9 idle lines", {ser_clk, ser_load}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule